// File: doc/BRIEF.md
# Predicated Flag Update Unit

This block keeps the three programmable condition flags of a loop-controlled instruction dock (two general flags, A and B, and a control flag, C). It also decides, for every presented instruction, whether that instruction runs or is skipped. The decision comes from a 3-bit predicate field, the current A and B values and a zero indication supplied by an external loop counter.

When the presented instruction is the flag-update form of the set instruction and its predicate holds, A and B are rewritten. Each new value is the OR of any chosen subset of six literals: A, not A, B, not B, C and not C. Both results are formed from the old flag values, so the two flags change on the same clock edge. C is written from a separate control input (valid strobe plus value), which the surrounding dock raises when a move instruction executes. That write also only happens when the current instruction's predicate holds.

Top module: `flag_pred_unit`

## Requirements
- R1: After reset, flagA, flagB and flagC are all 0.
- R2: The predicate is instrWord[24:22]. Code 000 executes when loopZero=0 and A=0. Code 001 executes when loopZero=0 and A=1. Code 010 executes when loopZero=0 and B=0. Code 011 executes when loopZero=0 and B=1. execOk reports the result combinationally.
- R3: Code 101 executes exactly when loopZero=1. Code 110 executes exactly when loopZero=0. Code 111 always executes.
- R4: Code 100 never executes.
- R5: A and B are updated only by a flag-update instruction: instrValid=1, instrWord[21:19]=101 and instrWord[18:15]=0001. Any other word leaves A and B unchanged.
- R6: The select field for A is instrWord[11:6] and the select field for B is instrWord[5:0]. Bits 5 down to 0 of a select field choose A, not A, B, not B, C, not C in that order. The new flag is the OR of the chosen literals, visible on the cycle after the clock edge.
- R7: A select field of all zeros yields 0. Choosing a flag together with its complement yields 1.
- R8: Both new values are computed from the flag values held before the update. For example, with A=1 and B=0, selecting B for A and A for B gives A=0 and B=1.
- R9: When ctrlValid=1 and the current valid instruction executes, flagC takes ctrlValue after the clock edge.
- R10: When the predicate evaluates false, no flag changes, whatever the instruction word or the control input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| instrWord | input | 25 | Instruction word |
| loopZero | input | 1 | Loop counter equals zero |
| ctrlValid | input | 1 | Request to write the control flag |
| ctrlValue | input | 1 | Value for the control flag |
| execOk | output | 1 | Predicate of the presented instruction holds |
| flagA | output | 1 | General flag A |
| flagB | output | 1 | General flag B |
| flagC | output | 1 | Control flag C |

## Verification
The hardest cases to reach are flag updates that start from a specific old state, especially one where C differs from A and B. Only the block's own instructions can set up such a state. The bench therefore builds every one of the eight A/B/C states in a single cycle: a flag-update word with an always-true predicate picks a flag-and-complement pair or an empty select, while the control input writes C in the same cycle. From each state it then applies all 64 A-select patterns, paired with scrambled B-select patterns, and sweeps all eight predicate codes under both loopZero values.

// File: rtl/flag_pred_pkg.sv
package flag_pred_pkg;

  typedef enum logic [2:0] {
    PRED_A_CLR  = 3'b000,
    PRED_A_SET  = 3'b001,
    PRED_B_CLR  = 3'b010,
    PRED_B_SET  = 3'b011,
    PRED_NEVER  = 3'b100,
    PRED_ZERO   = 3'b101,
    PRED_NZERO  = 3'b110,
    PRED_ALWAYS = 3'b111
  } predCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic updAB;
    logic wrC;
    logic cVal;
  } flagStrobe_t;

endpackage

// File: rtl/flag_pred_ctrl.sv
module flag_pred_ctrl
  import flag_pred_pkg::*;
#(
  parameter int PRED_W = 3,
  parameter int OP_W   = 3,
  parameter int DEST_W = 4,
  parameter logic [OP_W-1:0]   OP_SET    = 3'b101,
  parameter logic [DEST_W-1:0] DEST_FLAG = 4'b0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [PRED_W-1:0] predField,
  input  logic [OP_W-1:0]   opField,
  input  logic [DEST_W-1:0] destField,
  input  logic              loopZero,
  input  logic              curA,
  input  logic              curB,
  input  logic              ctrlValid,
  input  logic              ctrlValue,
  output logic              execOk,
  output flagStrobe_t       stb
);

  predCode_t predCode;
  logic isFlagSet;
  logic fire;

  assign predCode  = predCode_t'(predField);
  assign isFlagSet = (opField == OP_SET) && (destField == DEST_FLAG);

  always_comb begin
    unique case (predCode)
      PRED_A_CLR:  execOk = !loopZero && !curA;
      PRED_A_SET:  execOk = !loopZero &&  curA;
      PRED_B_CLR:  execOk = !loopZero && !curB;
      PRED_B_SET:  execOk = !loopZero &&  curB;
      PRED_NEVER:  execOk = 1'b0;
      PRED_ZERO:   execOk = loopZero;
      PRED_NZERO:  execOk = !loopZero;
      PRED_ALWAYS: execOk = 1'b1;
      default:     execOk = 1'b0;
    endcase
  end

  assign fire      = instrValid && execOk;
  assign stb.updAB = fire && isFlagSet;
  assign stb.wrC   = fire && ctrlValid;
  assign stb.cVal  = ctrlValue;

  AST_CODE_NEVER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (predField == 3'b100) |-> !execOk); // R4
  AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (predField == 3'b111) |-> execOk); // R3
  AST_FALSE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !execOk |-> !(stb.updAB || stb.wrC)); // R10

endmodule

// File: rtl/flag_pred_dp.sv
module flag_pred_dp
  import flag_pred_pkg::*;
#(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobe_t      stb,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  output logic             flagA,
  output logic             flagB,
  output logic             flagC
);

  localparam int NUM_GP = 2;

  logic [NUM_GP-1:0] gpReg;
  logic              cReg;
  logic [SEL_W-1:0]  lits;
  logic [SEL_W-1:0]  selArr [NUM_GP];
  logic [NUM_GP-1:0] nextGp;

  // literal order, msb first: A, ~A, B, ~B, C, ~C
  assign lits      = {gpReg[0], ~gpReg[0], gpReg[1], ~gpReg[1], cReg, ~cReg};
  assign selArr[0] = selA;
  assign selArr[1] = selB;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_orsel
    assign nextGp[g] = |(selArr[g] & lits);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpReg <= '0;
      cReg  <= 1'b0;
    end else begin
      if (stb.updAB) gpReg <= nextGp;
      if (stb.wrC)   cReg  <= stb.cVal;
    end
  end

  assign flagA = gpReg[0];
  assign flagB = gpReg[1];
  assign flagC = cReg;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.updAB || stb.wrC) |=> $stable({flagA, flagB, flagC})); // R10
  AST_C_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrC |=> (flagC == $past(stb.cVal))); // R9
  AST_EMPTY_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updAB && selA == '0) |=> !flagA); // R7
  AST_PAIR_SEL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updAB && selB[5] && selB[4]) |=> flagB); // R7

endmodule

// File: rtl/flag_pred_unit.sv
module flag_pred_unit
  import flag_pred_pkg::*;
#(
  parameter int INSTR_W = 25,
  parameter int PRED_W  = 3,
  parameter int OP_W    = 3,
  parameter int DEST_W  = 4,
  parameter int SEL_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               loopZero,
  input  logic               ctrlValid,
  input  logic               ctrlValue,
  output logic               execOk,
  output logic               flagA,
  output logic               flagB,
  output logic               flagC
);

  localparam int PRED_LO = INSTR_W - PRED_W;
  localparam int OP_LO   = PRED_LO - OP_W;
  localparam int DEST_LO = OP_LO - DEST_W;

  flagStrobe_t stb;

  flag_pred_ctrl #(
    .PRED_W(PRED_W), .OP_W(OP_W), .DEST_W(DEST_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .predField (instrWord[INSTR_W-1:PRED_LO]),
    .opField   (instrWord[PRED_LO-1:OP_LO]),
    .destField (instrWord[OP_LO-1:DEST_LO]),
    .loopZero  (loopZero),
    .curA      (flagA),
    .curB      (flagB),
    .ctrlValid (ctrlValid),
    .ctrlValue (ctrlValue),
    .execOk    (execOk),
    .stb       (stb)
  );

  flag_pred_dp #(.SEL_W(SEL_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .selA (instrWord[2*SEL_W-1:SEL_W]),
    .selB (instrWord[SEL_W-1:0]),
    .flagA(flagA),
    .flagB(flagB),
    .flagC(flagC)
  );

endmodule

// File: tb/test_flag_pred_unit.sv
`timescale 1ns/1ps
module test_flag_pred_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [24:0] instrWord = '0;
  logic loopZero = 1'b0;
  logic ctrlValid = 1'b0;
  logic ctrlValue = 1'b0;
  logic execOk, flagA, flagB, flagC;

  int checks = 0;
  int failures = 0;
  bit mA = 0, mB = 0, mC = 0;

  always #10 clk = ~clk;

  flag_pred_unit i_flag_pred_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .loopZero(loopZero), .ctrlValid(ctrlValid), .ctrlValue(ctrlValue),
    .execOk(execOk), .flagA(flagA), .flagB(flagB), .flagC(flagC)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [24:0] mkFlagSet(input logic [2:0] p, input logic [5:0] sa,
                                           input logic [5:0] sb);
    return {p, 3'b101, 4'b0001, 3'b000, sa, sb};
  endfunction

  function automatic bit predExp(input logic [2:0] p, input bit z, input bit a, input bit b);
    case (p)
      3'd0: return !z && !a;
      3'd1: return !z && a;
      3'd2: return !z && !b;
      3'd3: return !z && b;
      3'd5: return z;
      3'd6: return !z;
      3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit orSel(input logic [5:0] s, input bit a, input bit b, input bit c);
    bit [5:0] lit;
    lit = {a, !a, b, !b, c, !c};
    for (int k = 0; k < 6; k++) if (s[k] && lit[k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic [24:0] w, input bit z, input bit cv, input bit cval,
                      input string req);
    bit ex, isSet, nA, nB;
    @(negedge clk);
    instrValid = 1'b1; instrWord = w; loopZero = z; ctrlValid = cv; ctrlValue = cval;
    #2;
    ex = predExp(w[24:22], z, mA, mB);
    chk({req, " execOk"}, execOk, ex);
    isSet = (w[21:19] == 3'b101) && (w[18:15] == 4'b0001);
    nA = orSel(w[11:6], mA, mB, mC);
    nB = orSel(w[5:0], mA, mB, mC);
    if (ex && isSet) begin mA = nA; mB = nB; end
    if (ex && cv) mC = cval;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0; ctrlValid = 1'b0;
    chk({req, " flags"}, {flagA, flagB, flagC}, {mA, mB, mC});
  endtask

  task automatic setState(input bit a, input bit b, input bit c);
    step(mkFlagSet(3'b111, a ? 6'b110000 : 6'b0, b ? 6'b001100 : 6'b0), 1'b0, 1'b1, c,
         "R7_R9");
  endtask

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 reset", {flagA, flagB, flagC}, 0);

    // R2 R3 R4 R5: predicate sweep over all states, codes, zero values
    for (int s = 0; s < 8; s++) begin
      setState(s[2], s[1], s[0]);
      for (int z = 0; z < 2; z++) begin
        for (int p = 0; p < 8; p++) begin
          string tag;
          tag = (p < 4) ? "R2" : (p == 4) ? "R4" : "R3";
          // shift-like word: not a flag update, R5
          step({p[2:0], 3'b100, 19'h7ffff}, z[0], 1'b0, 1'b0, {tag, "_R5"});
          // set with other destination: not a flag update, R5
          step({p[2:0], 3'b101, 4'b1000, 15'h7fff}, z[0], 1'b0, 1'b0, "R5");
        end
      end
    end

    // R6 R7: OR selection from every start state
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 64; i++) begin
        logic [5:0] sb;
        sb = 6'((i * 11 + 5) % 64);
        setState(s[2], s[1], s[0]);
        step(mkFlagSet(3'b111, i[5:0], sb), 1'b0, 1'b0, 1'b0,
             (i == 0 || i == 48 || i == 12 || i == 3) ? "R7" : "R6");
      end
    end

    // R8: swap A and B in one update
    setState(1'b1, 1'b0, 1'b0);
    step(mkFlagSet(3'b111, 6'b001000, 6'b100000), 1'b0, 1'b0, 1'b0, "R8");
    chk("R8 swap", {flagA, flagB}, 2'b01);

    // R9: control write with an executing non-flag instruction
    step({3'b110, 3'b000, 19'h0}, 1'b0, 1'b1, 1'b1, "R9");
    chk("R9 C set", flagC, 1);
    step({3'b111, 3'b000, 19'h0}, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9 C clr", flagC, 0);

    // R10: false predicate blocks flag update and control write
    setState(1'b0, 1'b1, 1'b0);
    step(mkFlagSet(3'b100, 6'b110000, 6'b0), 1'b0, 1'b1, 1'b1, "R10");
    chk("R10 code4", {flagA, flagB, flagC}, 3'b010);
    step(mkFlagSet(3'b101, 6'b110000, 6'b0), 1'b0, 1'b1, 1'b1, "R10");
    step(mkFlagSet(3'b011, 6'b110000, 6'b0), 1'b1, 1'b1, 1'b1, "R10");
    chk("R10 zero", {flagA, flagB, flagC}, 3'b010);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule